// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer that software reaches through a small synchronous register port with 16-bit data. A prescaler divides the core clock into a coarse tick. While the watchdog runs, a 10-bit counter steps down by one on every tick. Software keeps the system alive by writing a reload key, which restarts the count from a programmed timeout. One tick stands for 0.6 s in the target system. The divide ratio is a parameter, so a short ratio can be used in simulation.

The counter expires when a tick arrives while it is already at zero. On the first expiry the block raises a first-stage flag and reloads the counter from the timeout. If the counter expires again while that flag is still set, the block raises a second-stage flag, reloads again and drives a system-reset pulse of fixed length. A no-reboot control bit suppresses the pulse without suppressing the flag. Both flags are cleared by writing 1 to them.

The control path has two small state machines. The countdown machine has two states. It moves from CD_HALTED to CD_RUNNING when a control write clears the halt bit, and back when a control write sets it. The pulse machine also has two states. It moves from PG_IDLE to PG_ASSERT on an unblocked second-stage expiry, and returns to PG_IDLE once RST_CYCLES clocks have passed.

Top module: `wdg_timer`

## Requirements
- R1: After reset the control register reads 0x0800 (halted, no-reboot clear), the timeout register reads 0x0004, the count reads 4, both status registers read 0 and `sys_rst_o` is low.
- R2: A read returns its data on `bus_rdata` in the cycle after `bus_rd_en`, and `bus_rdata` is 0 in every other cycle. The registers sit at byte offsets 0x00 (reload/count), 0x04 (status 1), 0x06 (status 2), 0x08 (control) and 0x12 (timeout). Any other offset reads 0 and ignores writes.
- R3: Control bit 11 is the halt bit: while it is 1 the count and the prescaler do not advance. Control bit 0 is the no-reboot bit. Both read back as written, and all other control bits read 0.
- R4: While running, a tick occurs every TICK_DIV clocks, counted from the clock that follows the un-halt write. Each tick lowers a nonzero count by one.
- R5: A write of exactly 0x0001 to offset 0x00 loads the count from the timeout field and takes priority over a tick in the same cycle. Any other value written there has no effect.
- R6: Timeout bits 9:0 take a written value only if that value is 4 or more. Bits 15:10 store whatever is written.
- R7: A tick at count 0 with status 1 bit 3 clear sets that bit and reloads the count from the timeout field, without a reset pulse.
- R8: A tick at count 0 with status 1 bit 3 already set sets status 2 bit 1 and reloads the count. If control bit 0 was clear, `sys_rst_o` is high for RST_CYCLES clocks, starting in the following clock. A further expiry during the pulse does not restart it.
- R9: Writing 1 to status 1 bit 3 or to status 2 bit 1 clears that bit, and writing 0 leaves it unchanged. A flag being set in the same cycle wins over its clear.
- R10: Reading offset 0x00 returns the live count in bits 9:0, with bits 15:10 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rd_en | input | 1 | Read request |
| bus_rdata | output | 16 | Read data, valid the cycle after the request |
| sys_rst_o | output | 1 | System-reset pulse on an unblocked second-stage expiry |

## Verification
Every register write takes effect at the clock edge that samples it. Read data appears one clock after the request, and the first tick after an un-halt lands TICK_DIV edges after the write edge. The reset pulse rises in the cycle after the edge that sees the second expiry and stays high for exactly RST_CYCLES cycles. The bench model updates its state at each rising edge from the inputs that edge sampled. The comparison with `bus_rdata` and `sys_rst_o` happens at the following falling edge, so every result is checked in the cycle it is due. Directed reads are timed from the write edges to land in known windows between expiries, and a falling-edge monitor counts reset-pulse cycles.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 5;

    // register byte offsets
    localparam logic [ADDR_W-1:0] OFS_KICK  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_FLAG1 = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_FLAG2 = 5'h06;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_TOUT  = 5'h12;

    // bit positions
    localparam int POS_HALT  = 11;
    localparam int POS_NOREB = 0;
    localparam int POS_STG1  = 3;
    localparam int POS_STG2  = 1;

    localparam logic [DATA_W-1:0] KICK_KEY = 16'h0001;
    localparam int TOUT_MIN = 4;

    typedef enum logic {
        CD_HALTED,
        CD_RUNNING
    } cd_state_e;

    typedef enum logic {
        PG_IDLE,
        PG_ASSERT
    } pg_state_e;

endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
    parameter int TICK_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] div_q;

    always_comb begin
        tick = run && (div_q == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + PW'(1);
        end
    end

endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown
    import wdg_pkg::*;
#(
    parameter int TW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          halt_wr,
    input  logic          halt_val,
    input  logic          reload_req,
    input  logic          tick,
    input  logic [TW-1:0] tout,
    output logic          running,
    output logic [TW-1:0] count,
    output logic          expire
);
    cd_state_e     state_q, state_d;
    logic [TW-1:0] count_q, count_d;

    // next state
    always_comb begin
        state_d = state_q;
        if (halt_wr) begin
            unique case (halt_val)
                1'b1: state_d = CD_HALTED;
                1'b0: state_d = CD_RUNNING;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CD_HALTED;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs and count datapath
    always_comb begin
        unique case (state_q)
            CD_HALTED:  running = 1'b0;
            CD_RUNNING: running = 1'b1;
        endcase
        count_d = count_q;
        expire  = 1'b0;
        if (reload_req) begin
            count_d = tout;
        end else if (tick) begin
            if (count_q == '0) begin
                expire  = 1'b1;
                count_d = tout;
            end else begin
                count_d = count_q - TW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= TW'(TOUT_MIN);
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !reload_req) |=> $stable(count)); // R3
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !reload_req && count != '0) |=> (count == $past(count) - TW'(1))); // R4
    AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        reload_req |=> (count == $past(tout))); // R5

endmodule

// File: rtl/wdg_rstgen.sv
module wdg_rstgen
    import wdg_pkg::*;
#(
    parameter int RST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic sys_rst
);
    localparam int CW = $clog2(RST_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

    pg_state_e     state_q, state_d;
    logic [CW-1:0] len_q, len_d;

    always_comb begin
        state_d = state_q;
        len_d   = len_q;
        unique case (state_q)
            PG_IDLE: begin
                len_d = '0;
                if (fire) begin
                    state_d = PG_ASSERT;
                end
            end
            PG_ASSERT: begin
                if (len_q == LAST) begin
                    state_d = PG_IDLE;
                    len_d   = '0;
                end else begin
                    len_d = len_q + CW'(1);
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PG_IDLE;
            len_q   <= '0;
        end else begin
            state_q <= state_d;
            len_q   <= len_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            PG_IDLE:   sys_rst = 1'b0;
            PG_ASSERT: sys_rst = 1'b1;
        endcase
    end

    AST_PULSE_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PG_ASSERT) |-> (len_q < CW'(RST_CYCLES))); // R8

endmodule

// File: rtl/wdg_regbank.sv
module wdg_regbank
    import wdg_pkg::*;
#(
    parameter int TW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    input  logic              running,
    input  logic [TW-1:0]     count,
    input  logic              expire,
    output logic              halt_wr,
    output logic              halt_val,
    output logic              reload_req,
    output logic [TW-1:0]     tout,
    output logic              fire,
    output logic              noreboot
);
    localparam int HW = DATA_W - TW;

    logic              norb_q;
    logic [TW-1:0]     tlo_q;
    logic [HW-1:0]     thi_q;
    logic              stg1_q, stg2_q;
    logic [DATA_W-1:0] rd_q, rd_mux;
    logic              wr_kick, wr_f1, wr_f2, wr_ctrl, wr_tout;
    logic              first_exp, second_exp;

    always_comb begin
        wr_kick = wr_en && (addr == OFS_KICK);
        wr_f1   = wr_en && (addr == OFS_FLAG1);
        wr_f2   = wr_en && (addr == OFS_FLAG2);
        wr_ctrl = wr_en && (addr == OFS_CTRL);
        wr_tout = wr_en && (addr == OFS_TOUT);
    end

    assign halt_wr    = wr_ctrl;
    assign halt_val   = wdata[POS_HALT];
    assign reload_req = wr_kick && (wdata == KICK_KEY);
    assign tout       = tlo_q;
    assign noreboot   = norb_q;
    assign first_exp  = expire && !stg1_q;
    assign second_exp = expire && stg1_q;
    assign fire       = second_exp && !norb_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            norb_q <= 1'b0;
            tlo_q  <= TW'(TOUT_MIN);
            thi_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                norb_q <= wdata[POS_NOREB];
            end
            if (wr_tout) begin
                thi_q <= wdata[DATA_W-1:TW];
                if (wdata[TW-1:0] >= TW'(TOUT_MIN)) begin
                    tlo_q <= wdata[TW-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg1_q <= 1'b0;
            stg2_q <= 1'b0;
        end else begin
            if (first_exp) begin
                stg1_q <= 1'b1;
            end else if (wr_f1 && wdata[POS_STG1]) begin
                stg1_q <= 1'b0;
            end
            if (second_exp) begin
                stg2_q <= 1'b1;
            end else if (wr_f2 && wdata[POS_STG2]) begin
                stg2_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (addr)
            OFS_KICK:  rd_mux = {{HW{1'b0}}, count};
            OFS_FLAG1: rd_mux[POS_STG1] = stg1_q;
            OFS_FLAG2: rd_mux[POS_STG2] = stg2_q;
            OFS_CTRL: begin
                rd_mux[POS_HALT]  = !running;
                rd_mux[POS_NOREB] = norb_q;
            end
            OFS_TOUT:  rd_mux = {thi_q, tlo_q};
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_en ? rd_mux : '0;
        end
    end

    assign rdata = rd_q;

    AST_STG2_NEEDS_STG1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stg2_q) |-> $past(stg1_q)); // R8
    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> (rdata == '0)); // R2
    AST_TOUT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        tout >= TW'(TOUT_MIN)); // R6
    AST_W1C_STG1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_f1 && wdata[POS_STG1] && !expire) |=> !stg1_q); // R9

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
    import wdg_pkg::*;
#(
    parameter int TICK_DIV   = 16,
    parameter int RST_CYCLES = 8,
    parameter int TOUT_W     = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  bus_addr,
    input  logic        bus_wr_en,
    input  logic [15:0] bus_wdata,
    input  logic        bus_rd_en,
    output logic [15:0] bus_rdata,
    output logic        sys_rst_o
);
    logic              tick, running, expire;
    logic              halt_wr, halt_val, reload_req, fire, noreboot;
    logic [TOUT_W-1:0] count, tout;

    wdg_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .tick  (tick)
    );

    wdg_countdown #(.TW(TOUT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_wr    (halt_wr),
        .halt_val   (halt_val),
        .reload_req (reload_req),
        .tick       (tick),
        .tout       (tout),
        .running    (running),
        .count      (count),
        .expire     (expire)
    );

    wdg_regbank #(.TW(TOUT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (bus_addr),
        .wr_en      (bus_wr_en),
        .wdata      (bus_wdata),
        .rd_en      (bus_rd_en),
        .rdata      (bus_rdata),
        .running    (running),
        .count      (count),
        .expire     (expire),
        .halt_wr    (halt_wr),
        .halt_val   (halt_val),
        .reload_req (reload_req),
        .tout       (tout),
        .fire       (fire),
        .noreboot   (noreboot)
    );

    wdg_rstgen #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .sys_rst (sys_rst_o)
    );

    AST_NOREBOOT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> !$past(noreboot)); // R8
    AST_EXPIRE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> running); // R4

endmodule

// File: tb/wdg_timer_tb.sv
module wdg_timer_tb;
    localparam int P   = 4;
    localparam int RST = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  b_addr = '0;
    logic        b_wr = 1'b0;
    logic [15:0] b_wdata = '0;
    logic        b_rd = 1'b0;
    logic [15:0] b_rdata;
    logic        sys_rst;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int rst_hi_cnt = 0;

    // reference model state
    int m_count, m_tout_lo, m_tout_hi, m_halt, m_nr, m_f1, m_f2, m_pc, m_pl;
    int m_rd;

    always #2 clk = ~clk;

    wdg_timer #(.TICK_DIV(P), .RST_CYCLES(RST), .TOUT_W(10)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (b_addr),
        .bus_wr_en (b_wr),
        .bus_wdata (b_wdata),
        .bus_rd_en (b_rd),
        .bus_rdata (b_rdata),
        .sys_rst_o (sys_rst)
    );

    function automatic int model_read(int a);
        case (a)
            'h00: return m_count;
            'h04: return m_f1 * 8;
            'h06: return m_f2 * 2;
            'h08: return m_halt * 'h800 + m_nr;
            'h12: return m_tout_hi * 1024 + m_tout_lo;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_count = 4; m_tout_lo = 4; m_tout_hi = 0; m_halt = 1; m_nr = 0;
            m_f1 = 0; m_f2 = 0; m_pc = 0; m_pl = 0; m_rd = 0;
        end else begin
            int a, d, tick_i, kick, exp_i, n_count, n_pc, n_f1, n_f2, n_pl, n_rd;
            a = int'(b_addr);
            d = int'(b_wdata);
            tick_i = (m_halt == 0 && m_pc == P - 1) ? 1 : 0;
            n_pc = (m_halt == 1 || tick_i == 1) ? 0 : m_pc + 1;
            kick = (b_wr && a == 'h00 && d == 1) ? 1 : 0;
            exp_i = (tick_i == 1 && kick == 0 && m_count == 0) ? 1 : 0;
            n_count = m_count;
            if (kick == 1) n_count = m_tout_lo;
            else if (tick_i == 1) n_count = (m_count == 0) ? m_tout_lo : m_count - 1;
            n_rd = b_rd ? model_read(a) : 0;
            n_f1 = m_f1; n_f2 = m_f2;
            if (exp_i == 1 && m_f1 == 0) n_f1 = 1;
            else if (b_wr && a == 'h04 && d[3]) n_f1 = 0;
            if (exp_i == 1 && m_f1 == 1) n_f2 = 1;
            else if (b_wr && a == 'h06 && d[1]) n_f2 = 0;
            n_pl = m_pl;
            if (m_pl > 0) n_pl = m_pl - 1;
            else if (exp_i == 1 && m_f1 == 1 && m_nr == 0) n_pl = RST;
            if (b_wr && a == 'h08) begin
                m_halt = d[11];
                m_nr = d[0];
            end
            if (b_wr && a == 'h12) begin
                m_tout_hi = d / 1024;
                if ((d % 1024) >= 4) m_tout_lo = d % 1024;
            end
            m_count = n_count; m_pc = n_pc; m_f1 = n_f1; m_f2 = n_f2;
            m_pl = n_pl; m_rd = n_rd;
        end
    end

    // every-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_tests++;
            if (int'(b_rdata) != m_rd) begin
                n_fail++;
                $display("FAIL R2 cycle read data: actual %h expected %h", b_rdata, m_rd[15:0]);
            end
            n_tests++;
            if (int'(sys_rst) != ((m_pl > 0) ? 1 : 0)) begin
                n_fail++;
                $display("FAIL R8 reset output: actual %0d expected %0d", sys_rst, (m_pl > 0));
            end
            if (sys_rst) rst_hi_cnt++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // both tasks start just after a falling edge and end on one
    task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
        b_addr = a; b_wdata = d; b_wr = 1'b1;
        @(negedge clk);
        b_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output int v);
        b_addr = a; b_rd = 1'b1;
        @(negedge clk);
        v = int'(b_rdata);
        b_rd = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset out", int'(sys_rst), 0);
        bus_read(5'h08, v); chk("R1 ctrl reset", v, 'h0800);
        bus_read(5'h12, v); chk("R1 tout reset", v, 'h0004);
        bus_read(5'h04, v); chk("R1 sts1 reset", v, 0);
        bus_read(5'h06, v); chk("R1 sts2 reset", v, 0);
        bus_read(5'h00, v); chk("R1 R10 count reset", v, 4);
        // timeout field rules
        bus_write(5'h12, 16'h0003);
        bus_read(5'h12, v); chk("R6 below-min ignored", v, 'h0004);
        bus_write(5'h12, 16'hFC08);
        bus_read(5'h12, v); chk("R6 upper bits stored", v, 'hFC08);
        bus_write(5'h12, 16'h0008);
        bus_read(5'h12, v); chk("R6 timeout 8", v, 'h0008);
        // reload key
        bus_write(5'h00, 16'h0002);
        bus_read(5'h00, v); chk("R5 wrong key no effect", v, 4);
        bus_write(5'h00, 16'h0001);
        bus_read(5'h00, v); chk("R5 R10 reload", v, 8);
        repeat (20) @(negedge clk);
        bus_read(5'h00, v); chk("R3 halted count frozen", v, 8);
        // unhalt
        bus_write(5'h08, 16'h0000);
        bus_read(5'h08, v); chk("R3 ctrl readback running", v, 0);
        bus_read(5'h00, v); chk("R4 count before first tick", v, 8);
        repeat (8) @(negedge clk);
        bus_read(5'h00, v); chk("R4 two ticks elapsed", v, 6);
        // first expiry window
        repeat (30) @(negedge clk);
        bus_read(5'h04, v); chk("R7 stage-1 flag", v, 'h0008);
        bus_read(5'h00, v); chk("R7 reloaded count", v, 7);
        bus_read(5'h06, v); chk("R7 no stage-2 flag", v, 0);
        chk("R7 no reset pulse", rst_hi_cnt, 0);
        // second expiry and pulse
        repeat (44) @(negedge clk);
        bus_read(5'h06, v); chk("R8 stage-2 flag", v, 'h0002);
        chk("R8 pulse length", rst_hi_cnt, RST);
        // write-1-to-clear
        bus_write(5'h04, 16'h0000);
        bus_read(5'h04, v); chk("R9 write 0 keeps flag", v, 'h0008);
        bus_write(5'h04, 16'h0008);
        bus_read(5'h04, v); chk("R9 stage-1 cleared", v, 0);
        bus_write(5'h06, 16'h0002);
        bus_read(5'h06, v); chk("R9 stage-2 cleared", v, 0);
        // no-reboot gate
        bus_write(5'h08, 16'h0001);
        bus_read(5'h08, v); chk("R3 no-reboot readback", v, 'h0001);
        repeat (60) @(negedge clk);
        bus_read(5'h06, v); chk("R8 stage-2 under no-reboot", v, 'h0002);
        bus_read(5'h04, v); chk("R7 stage-1 again", v, 'h0008);
        chk("R8 no-reboot blocks pulse", rst_hi_cnt, RST);
        // unmapped offset
        bus_write(5'h0A, 16'hFFFF);
        bus_read(5'h0A, v); chk("R2 unmapped reads 0", v, 0);
        bus_read(5'h08, v); chk("R2 unmapped write ignored ctrl", v, 'h0001);
        bus_read(5'h12, v); chk("R2 unmapped write ignored tout", v, 'h0008);
        // halt again and hold
        bus_write(5'h08, 16'h0800);
        bus_read(5'h00, v);
        repeat (12) @(negedge clk);
        begin
            int w;
            bus_read(5'h00, w); chk("R3 re-halted frozen", w, v);
        end
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule